// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block tracks up to four nested zero-overhead loops for a processor core. Loop setup pushes a frame that holds an iteration counter, the first address of the loop body and the last address of the loop body. The controller watches the 18-bit program counter of each retiring instruction. When that address equals the last address of the innermost (top) frame, one of two things happens. If the counter is nonzero, the controller sends fetch back to the body start in that same cycle and decrements the counter. If the counter is zero, it drops the frame and execution falls through.

The counter is loaded with the iteration count minus one. The program-visible loop counter is always the counter of the top frame. A software write to that register changes only the top frame. Software can also discard the top frame with an explicit pop. A push onto a full stack and a pop from an empty stack are both ignored, and each one raises a one-cycle flag.

Frames are kept in a single-write-port array that can be mapped to distributed RAM. Only the depth pointer and the flags are reset.

Top module: `lbs_loop_ctrl`

## Requirements
- R1: `depth_o` counts the stored frames, is 0 after reset, and never exceeds 4.
- R2: A push with free space stores the count, start and end, and `depth_o` increases by one. One cycle later `lc_o` equals the pushed count.
- R3: `lc_o` always equals the counter of the top frame, and reads 0 when the stack is empty. After the top frame is removed, `lc_o` shows the counter of the frame below it, unchanged.
- R4: A retirement whose address equals the top frame's end, while that frame's counter is nonzero, drives `redirect_o` high in the same cycle with `redirect_pc_o` equal to the top frame's start. On the next cycle the counter is one lower and the depth is unchanged.
- R5: A retirement that matches the top frame's end while its counter is 0 gives no redirect, and the frame is popped on the next cycle.
- R6: A retirement address that differs from the top frame's end, a match with `retire_vld_i` low, or any retirement on an empty stack has no effect on the depth, the counter or the redirect.
- R7: A push while 4 frames are stored is ignored. `ovf_o` is high for exactly the following cycle.
- R8: An explicit pop removes the top frame. A pop on an empty stack is ignored, and `udf_o` is high for the following cycle.
- R9: A write to the loop counter replaces only the top frame's counter. The frames below it are unchanged, and the write is ignored when the stack is empty.
- R10: When several requests arrive in one cycle, only the highest-priority one takes effect. The order is push, then pop, then end match, then counter write. `redirect_o` stays low whenever a push or a pop is present.
- R11: Only the top frame's end address is compared. An address that matches the end of an outer frame does nothing while an inner frame is on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Loop setup: push a new frame |
| push_cnt_i | input | 16 | Iteration count minus one for the new frame |
| push_start_i | input | 18 | First address of the loop body |
| push_end_i | input | 18 | Last address of the loop body |
| pop_i | input | 1 | Discard the top frame |
| retire_vld_i | input | 1 | An instruction is retiring this cycle |
| retire_pc_i | input | 18 | Address of the retiring instruction |
| lc_wr_i | input | 1 | Write the visible loop counter |
| lc_wdata_i | input | 16 | Value for the loop counter write |
| redirect_o | output | 1 | Loop back taken this cycle |
| redirect_pc_o | output | 18 | Fetch target when redirecting |
| lc_o | output | 16 | Top frame counter (0 when empty) |
| depth_o | output | 3 | Number of stored frames |
| ovf_o | output | 1 | Previous cycle pushed onto a full stack |
| udf_o | output | 1 | Previous cycle popped an empty stack |

## Verification
A wrong depth pointer shows up one cycle after the fault. `depth_o` reads wrong, and `lc_o` presents the counter of the wrong frame, so the bench reads both after every push, pop and loop exit. A corrupted counter or body start appears at the next end-address match. In that cycle `redirect_o` or `redirect_pc_o` is wrong, and the loop exits one pass early or late. The bench therefore walks complete loops and samples the redirect in the matching cycle itself. Writes that land on a lower frame stay hidden until the top frame is removed, so the bench pops after each counter write and checks the uncovered counter.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PUSH,
    ACT_POP,
    ACT_LOOP,
    ACT_EXIT,
    ACT_LCWR,
    ACT_OVF,
    ACT_UDF
  } lbs_act_e;
endpackage

// File: rtl/lbs_frame_ram.sv
module lbs_frame_ram #(
  parameter int DEPTH = 4,
  parameter int WW    = 52,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  // no reset on the array so it maps onto distributed RAM
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lbs_arbiter.sv
module lbs_arbiter
  import lbs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 18,
  parameter int CW    = 16,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WW   = CW + 2 * AW
) (
  input  logic          push,
  input  logic [CW-1:0] push_cnt,
  input  logic [AW-1:0] push_start,
  input  logic [AW-1:0] push_end,
  input  logic          pop,
  input  logic          retire_vld,
  input  logic [AW-1:0] retire_pc,
  input  logic          lc_wr,
  input  logic [CW-1:0] lc_wdata,
  input  logic [DW-1:0] depth,
  input  logic [WW-1:0] top_word,
  output lbs_act_e      act,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [WW-1:0] wdata
);
  logic          empty, full, hit;
  logic [CW-1:0] top_cnt;
  logic [AW-1:0] top_start, top_end;
  logic [IW-1:0] top_idx;

  assign {top_cnt, top_start, top_end} = top_word;
  assign empty   = (depth == '0);
  assign full    = (depth == DW'(DEPTH));
  assign top_idx = IW'(depth - DW'(1));
  assign hit     = retire_vld && !empty && (retire_pc == top_end);

  always_comb begin
    act = ACT_NONE;
    if (push)                    act = full  ? ACT_OVF : ACT_PUSH;
    else if (pop)                act = empty ? ACT_UDF : ACT_POP;
    else if (hit)                act = (top_cnt != '0) ? ACT_LOOP : ACT_EXIT;
    else if (lc_wr && !empty)    act = ACT_LCWR;
  end

  always_comb begin
    we    = 1'b0;
    waddr = top_idx;
    wdata = top_word;
    unique case (act)
      ACT_PUSH: begin
        we    = 1'b1;
        waddr = IW'(depth);
        wdata = {push_cnt, push_start, push_end};
      end
      ACT_LOOP: begin
        we    = 1'b1;
        wdata = {top_cnt - CW'(1), top_start, top_end};
      end
      ACT_LCWR: begin
        we    = 1'b1;
        wdata = {lc_wdata, top_start, top_end};
      end
      default: ;
    endcase
  end

  assign redirect    = (act == ACT_LOOP);
  assign redirect_pc = top_start;
endmodule

// File: rtl/lbs_depth_ptr.sv
module lbs_depth_ptr
  import lbs_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  lbs_act_e      act,
  output logic [DW-1:0] depth,
  output logic          ovf,
  output logic          udf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
      ovf   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      ovf <= (act == ACT_OVF);
      udf <= (act == ACT_UDF);
      case (act)
        ACT_PUSH:         depth <= depth + DW'(1);
        ACT_POP, ACT_EXIT: depth <= depth - DW'(1);
        default: ;
      endcase
    end
  end

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= DW'(DEPTH));

  // R1
  depth_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (depth == $past(depth) || depth == $past(depth) + DW'(1)
                     || depth == $past(depth) - DW'(1)));
endmodule

// File: rtl/lbs_loop_ctrl.sv
module lbs_loop_ctrl
  import lbs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 18,
  parameter int CW    = 16,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WW   = CW + 2 * AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [CW-1:0] push_cnt_i,
  input  logic [AW-1:0] push_start_i,
  input  logic [AW-1:0] push_end_i,
  input  logic          pop_i,
  input  logic          retire_vld_i,
  input  logic [AW-1:0] retire_pc_i,
  input  logic          lc_wr_i,
  input  logic [CW-1:0] lc_wdata_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic [CW-1:0] lc_o,
  output logic [DW-1:0] depth_o,
  output logic          ovf_o,
  output logic          udf_o
);
  lbs_act_e      act;
  logic          we;
  logic [IW-1:0] waddr, raddr;
  logic [WW-1:0] wdata, top_word;

  assign raddr = IW'(depth_o - DW'(1));

  lbs_frame_ram #(.DEPTH(DEPTH), .WW(WW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (top_word)
  );

  lbs_arbiter #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_arb (
    .push        (push_i),
    .push_cnt    (push_cnt_i),
    .push_start  (push_start_i),
    .push_end    (push_end_i),
    .pop         (pop_i),
    .retire_vld  (retire_vld_i),
    .retire_pc   (retire_pc_i),
    .lc_wr       (lc_wr_i),
    .lc_wdata    (lc_wdata_i),
    .depth       (depth_o),
    .top_word    (top_word),
    .act         (act),
    .redirect    (redirect_o),
    .redirect_pc (redirect_pc_o),
    .we          (we),
    .waddr       (waddr),
    .wdata       (wdata)
  );

  lbs_depth_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .depth (depth_o),
    .ovf   (ovf_o),
    .udf   (udf_o)
  );

  assign lc_o = (depth_o == '0) ? '0 : top_word[WW-1 -: CW];

  // R4
  loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> (lc_o == $past(lc_o) - CW'(1)) && (depth_o == $past(depth_o)));

  // R10
  redirect_excl_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> !push_i && !pop_i);

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> depth_o == DW'(DEPTH));

  // R8
  udf_empty_chk: assert property (@(posedge clk) disable iff (rst)
    udf_o |-> depth_o == '0);

  // R3
  empty_lc_chk: assert property (@(posedge clk) disable iff (rst)
    (depth_o == '0) |-> lc_o == '0);
endmodule

// File: tb/sim_lbs_loop_ctrl.sv
module sim_lbs_loop_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        push_i, pop_i, retire_vld_i, lc_wr_i;
  logic [15:0] push_cnt_i, lc_wdata_i;
  logic [17:0] push_start_i, push_end_i, retire_pc_i;
  logic        redirect_o, ovf_o, udf_o;
  logic [17:0] redirect_pc_o;
  logic [15:0] lc_o;
  logic [2:0]  depth_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lbs_loop_ctrl u0 (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    push_i = 0; pop_i = 0; retire_vld_i = 0; lc_wr_i = 0;
    push_cnt_i = 0; push_start_i = 0; push_end_i = 0;
    retire_pc_i = 0; lc_wdata_i = 0;
  endtask

  // advance one clock, leaving the bench at the next falling edge
  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic do_push(logic [15:0] c, logic [17:0] s, logic [17:0] e);
    push_i = 1; push_cnt_i = c; push_start_i = s; push_end_i = e;
    step();
  endtask

  task automatic do_pop();
    pop_i = 1; step();
  endtask

  task automatic retire(logic [17:0] pc, string req, bit exp_redir, logic [17:0] exp_pc);
    retire_vld_i = 1; retire_pc_i = pc; #1;
    chk(req, "redirect", redirect_o, exp_redir);
    if (exp_redir) chk(req, "redirect_pc", redirect_pc_o, exp_pc);
    step();
  endtask

  task automatic t_reset();
    chk("R1", "depth after reset", depth_o, 0);
    chk("R3", "lc empty", lc_o, 0);
    chk("R7", "ovf after reset", ovf_o, 0);
    chk("R8", "udf after reset", udf_o, 0);
    chk("R6", "redirect idle", redirect_o, 0);
  endtask

  task automatic t_fill();
    for (int i = 1; i <= 4; i++) begin
      do_push(16'(i * 10), 18'(i * 100), 18'(i * 100 + 9));
      chk("R2", "depth after push", depth_o, i);
      chk("R2", "lc after push", lc_o, i * 10);
    end
    do_push(16'd999, 18'd7, 18'd8);
    chk("R7", "ovf on full push", ovf_o, 1);
    chk("R7", "depth unchanged", depth_o, 4);
    chk("R7", "lc unchanged", lc_o, 40);
    step();
    chk("R7", "ovf one cycle", ovf_o, 0);
  endtask

  task automatic t_nested_match();
    retire(18'd109, "R11", 0, 0);
    chk("R11", "lc outer end", lc_o, 40);
    chk("R11", "depth outer end", depth_o, 4);
    retire(18'd408, "R6", 0, 0);
    chk("R6", "lc non-end", lc_o, 40);
    retire_pc_i = 18'd409; #1;
    chk("R6", "no redirect without valid", redirect_o, 0);
    step();
    chk("R6", "lc without valid", lc_o, 40);
    retire(18'd409, "R4", 1, 18'd400);
    chk("R4", "lc decremented", lc_o, 39);
    chk("R4", "depth kept", depth_o, 4);
  endtask

  task automatic t_lcwr();
    lc_wr_i = 1; lc_wdata_i = 16'd2; step();
    chk("R9", "top written", lc_o, 2);
    do_pop();
    chk("R8", "depth after pop", depth_o, 3);
    chk("R9", "lower frame untouched", lc_o, 30);
    chk("R3", "lc shows new top", lc_o, 30);
  endtask

  task automatic t_prio();
    push_i = 1; push_cnt_i = 16'd1; push_start_i = 18'd500; push_end_i = 18'd503;
    retire_vld_i = 1; retire_pc_i = 18'd309; #1;
    chk("R10", "no redirect with push", redirect_o, 0);
    step();
    chk("R10", "push won", depth_o, 4);
    chk("R10", "new top count", lc_o, 1);
    pop_i = 1; lc_wr_i = 1; lc_wdata_i = 16'd77; step();
    chk("R10", "pop beats write", depth_o, 3);
    chk("R10", "write dropped", lc_o, 30);
    retire_vld_i = 1; retire_pc_i = 18'd309; lc_wr_i = 1; lc_wdata_i = 16'd5; #1;
    chk("R10", "match beats write redirect", redirect_o, 1);
    step();
    chk("R10", "match beats write lc", lc_o, 29);
  endtask

  task automatic t_full_loop();
    do_push(16'd2, 18'd600, 18'd602);
    retire(18'd602, "R4", 1, 18'd600);
    retire(18'd602, "R4", 1, 18'd600);
    chk("R4", "count at zero", lc_o, 0);
    retire(18'd602, "R5", 0, 0);
    chk("R5", "frame popped", depth_o, 3);
    chk("R5", "outer count", lc_o, 29);
  endtask

  task automatic t_underflow();
    do_pop(); do_pop(); do_pop();
    chk("R8", "emptied", depth_o, 0);
    do_pop();
    chk("R8", "udf on empty", udf_o, 1);
    chk("R8", "depth stays", depth_o, 0);
    lc_wr_i = 1; lc_wdata_i = 16'd9; step();
    chk("R9", "write on empty ignored", lc_o, 0);
    chk("R8", "udf one cycle", udf_o, 0);
    retire(18'd0, "R6", 0, 0);
    chk("R6", "empty retire depth", depth_o, 0);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_fill();
    t_nested_match();
    t_lcwr();
    t_prio();
    t_full_loop();
    t_underflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule